// File: doc/BRIEF.md
# Cascadable Display Column Data Loader

This block is the digital front end of a column driver that can be chained with other drivers. Each clock carries one 36-bit word of six 6-bit gray codes. A start token enables loading. While it is active, each clock writes the six codes into the next group of six columns of a 384-column data register. The fill runs from the low-numbered end or from the high-numbered end, as the direction select chooses. About one line's worth of clocks after its own token arrives, the block raises a one-clock start pulse on the opposite side pin. That pulse starts the next device in the chain. The block also stops taking data by itself once its register is full.

A strobe ends each line. On its rising edge the whole register is copied into an output latch, the loading position is reset, and the polarity input is sampled. On its falling edge an output-valid flag is raised so that the latched codes can drive the converters downstream. The polarity input decides which reference half each column uses: odd and even columns always use opposite halves. A data-invert input complements codes as they are captured.

Top module: `cdl_loader`

## Requirements
- R1: A synchronous reset clears the data register, output latch, token, position and flags: all codes read 0, `valid_o` is 0 and both start-pulse outputs are 0.
- R2: With `dir_i` high, `sp_r_in` is the token input and the left pin is the output (`sp_l_oe`=1, `sp_r_oe`=0). Word dot k (bits [6k+5:6k]) of the g-th captured word (g from 0) goes to 0-based column 6g+k.
- R3: With `dir_i` low, `sp_l_in` is the token input and the right pin is the output (`sp_r_oe`=1, `sp_l_oe`=0). Dot k of the g-th captured word goes to 0-based column 383-6g-k, so dot 0 lands on the highest column of its group.
- R4: The clock that samples the token high is capture clock 1 and writes group 0. The output start pulse is high after the rising edge of capture clock 64 and not before.
- R5: The output start pulse stays high for exactly one clock.
- R6: Clocks after the 64th capture leave the data register unchanged until a new token arrives. The block stops counting after 66 clocks.
- R7: Codes are stored as the bitwise complement when `inv_i` is high on that capture clock, and unchanged when it is low.
- R8: The clock that sees `stb_i` go from 0 to 1 copies the data register into `codes_o` (column c at bits [6c+5:6c]). It also ends loading, so later clocks without a token write nothing.
- R9: `valid_o` rises on the clock that sees `stb_i` go from 1 to 0, and clears on the next strobe rising clock.
- R10: `half_o[c]`=1 selects the upper reference half. With `pol_i` sampled low at the strobe rise, even 0-based columns (odd 1-based) are 1 and odd 0-based columns are 0. A high sample swaps this.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| dir_i | input | 1 | Fill direction, 1 = ascending columns |
| sp_r_in | input | 1 | Right start-pulse pin, input side |
| sp_r_out | output | 1 | Right start-pulse pin, output side |
| sp_r_oe | output | 1 | Right pin output enable |
| sp_l_in | input | 1 | Left start-pulse pin, input side |
| sp_l_out | output | 1 | Left start-pulse pin, output side |
| sp_l_oe | output | 1 | Left pin output enable |
| stb_i | input | 1 | Line strobe |
| pol_i | input | 1 | Polarity select |
| inv_i | input | 1 | Data invert |
| data_i | input | 36 | Six 6-bit codes, dot k at bits [6k+5:6k] |
| codes_o | output | 2304 | Latched codes, column c at bits [6c+5:6c] |
| half_o | output | 384 | Reference half per column, 1 = upper |
| valid_o | output | 1 | Latched codes are driving the outputs |

## Verification
A position counter that is off by one does two things. The outgoing start pulse moves away from the clock after capture 64, which is seen at once on the pin. In addition, a whole group of codes lands in the wrong column or is lost, which is seen in `codes_o` at the next strobe. A direction or dot-order fault puts codes into mirrored columns and is caught by comparing the full latch against a bench model at each valid rise. A halt or clear that does not happen lets later garbage words or tokenless clocks overwrite columns, and the next line then shows the damage. A polarity-latch or valid-edge fault shows within one or two clocks of the strobe edges.

// File: rtl/cdl_pkg.sv
package cdl_pkg;
    localparam int DOT_W     = 6;
    localparam int DOTS      = 6;
    localparam int NUM_COLS  = 384;
    localparam int WORD_W    = DOT_W * DOTS;
    localparam int GROUPS    = NUM_COLS / DOTS;
    localparam int HALT_CLKS = GROUPS + 2;
endpackage

// File: rtl/cdl_token_ctrl.sv
module cdl_token_ctrl #(
    parameter int GROUPS    = cdl_pkg::GROUPS,
    parameter int HALT_CLKS = cdl_pkg::HALT_CLKS,
    localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1,
    localparam int IW = $clog2(HALT_CLKS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          clear_i,
    output logic          wr_en_o,
    output logic [GW-1:0] grp_o,
    output logic          sp_o
);
    typedef struct packed {
        logic          run;
        logic [IW-1:0] idx;
        logic          sp;
    } tok_st_t;

    tok_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sp = 1'b0;
        wr_en_o = 1'b0;
        grp_o   = GW'(st_q.idx);
        if (clear_i) begin
            st_d.run = 1'b0;
            st_d.idx = '0;
        end else if (start_i) begin
            wr_en_o  = 1'b1;
            grp_o    = '0;
            st_d.run = 1'b1;
            st_d.idx = IW'(1);
            st_d.sp  = (GROUPS == 1);
        end else if (st_q.run) begin
            if (st_q.idx < IW'(GROUPS)) begin
                wr_en_o = 1'b1;
                if (st_q.idx == IW'(GROUPS - 1)) st_d.sp = 1'b1;
            end
            if (st_q.idx == IW'(HALT_CLKS - 1)) begin
                st_d.run = 1'b0;
                st_d.idx = '0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign sp_o = st_q.sp;

    AST_SP_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        st_q.sp |=> !st_q.sp); // R5
    AST_SP_AFTER_LAST_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.sp) |-> $past(wr_en_o)); // R4
    AST_IDX_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        st_q.run |-> (st_q.idx < IW'(HALT_CLKS))); // R6
endmodule

// File: rtl/cdl_column_reg.sv
module cdl_column_reg #(
    parameter int GROUPS = cdl_pkg::GROUPS,
    parameter int DOTS   = cdl_pkg::DOTS,
    parameter int DOT_W  = cdl_pkg::DOT_W,
    localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1,
    localparam int WW = DOTS * DOT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en_i,
    input  logic [GW-1:0]      grp_i,
    input  logic               dir_i,
    input  logic               inv_i,
    input  logic [WW-1:0]      data_i,
    output logic [GROUPS*WW-1:0] words_o
);
    typedef struct packed {
        logic [GROUPS-1:0][WW-1:0] mem;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic [WW-1:0] word_inv, word_ord;
    logic [GW-1:0] phys;

    always_comb begin
        word_inv = data_i ^ {WW{inv_i}};
        word_ord = word_inv;
        if (!dir_i) begin
            for (int k = 0; k < DOTS; k++) begin
                word_ord[k*DOT_W +: DOT_W] = word_inv[(DOTS-1-k)*DOT_W +: DOT_W];
            end
        end
        phys = dir_i ? grp_i : (GW'(GROUPS - 1) - grp_i);
        st_d = st_q;
        if (wr_en_i) st_d.mem[phys] = word_ord;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign words_o = st_q.mem;
endmodule

// File: rtl/cdl_out_latch.sv
module cdl_out_latch #(
    parameter int NUM_COLS = cdl_pkg::NUM_COLS,
    parameter int DOT_W    = cdl_pkg::DOT_W,
    localparam int LW = NUM_COLS * DOT_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                stb_i,
    input  logic                pol_i,
    input  logic [LW-1:0]       words_i,
    output logic                stb_rise_o,
    output logic [LW-1:0]       codes_o,
    output logic [NUM_COLS-1:0] half_o,
    output logic                valid_o
);
    typedef struct packed {
        logic          stb_prev;
        logic          pol;
        logic          valid;
        logic [LW-1:0] lat;
    } lat_st_t;

    lat_st_t st_d, st_q;
    logic stb_fall;

    always_comb begin
        stb_rise_o    = stb_i & ~st_q.stb_prev;
        stb_fall      = ~stb_i & st_q.stb_prev;
        st_d          = st_q;
        st_d.stb_prev = stb_i;
        if (stb_rise_o) begin
            st_d.lat   = words_i;
            st_d.pol   = pol_i;
            st_d.valid = 1'b0;
        end else if (stb_fall) begin
            st_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    for (genvar c = 0; c < NUM_COLS; c++) begin : g_half
        if (c % 2 == 0) begin : g_odd_pin
            assign half_o[c] = ~st_q.pol;
        end else begin : g_even_pin
            assign half_o[c] = st_q.pol;
        end
    end

    assign codes_o = st_q.lat;
    assign valid_o = st_q.valid;

    AST_VALID_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.valid) |-> (!st_q.stb_prev && $past(st_q.stb_prev))); // R9
    AST_VALID_CLR_AT_RISE: assert property (@(posedge clk) disable iff (rst)
        $fell(st_q.valid) |-> st_q.stb_prev); // R9
endmodule

// File: rtl/cdl_loader.sv
module cdl_loader #(
    parameter int NUM_COLS = cdl_pkg::NUM_COLS,
    parameter int DOTS     = cdl_pkg::DOTS,
    parameter int DOT_W    = cdl_pkg::DOT_W,
    localparam int WW     = DOTS * DOT_W,
    localparam int GROUPS = NUM_COLS / DOTS,
    localparam int GW     = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      dir_i,
    input  logic                      sp_r_in,
    output logic                      sp_r_out,
    output logic                      sp_r_oe,
    input  logic                      sp_l_in,
    output logic                      sp_l_out,
    output logic                      sp_l_oe,
    input  logic                      stb_i,
    input  logic                      pol_i,
    input  logic                      inv_i,
    input  logic [WW-1:0]             data_i,
    output logic [NUM_COLS*DOT_W-1:0] codes_o,
    output logic [NUM_COLS-1:0]       half_o,
    output logic                      valid_o
);
    logic          start, stb_rise, wr_en, sp_pulse;
    logic [GW-1:0] grp;
    logic [GROUPS*WW-1:0] words;

    assign start    = dir_i ? sp_r_in : sp_l_in;
    assign sp_l_oe  = dir_i;
    assign sp_r_oe  = ~dir_i;
    assign sp_l_out = dir_i & sp_pulse;
    assign sp_r_out = ~dir_i & sp_pulse;

    cdl_token_ctrl #(.GROUPS(GROUPS), .HALT_CLKS(GROUPS + 2)) tok_i (
        .clk(clk), .rst(rst), .start_i(start), .clear_i(stb_rise),
        .wr_en_o(wr_en), .grp_o(grp), .sp_o(sp_pulse)
    );

    cdl_column_reg #(.GROUPS(GROUPS), .DOTS(DOTS), .DOT_W(DOT_W)) creg_i (
        .clk(clk), .rst(rst), .wr_en_i(wr_en), .grp_i(grp), .dir_i(dir_i),
        .inv_i(inv_i), .data_i(data_i), .words_o(words)
    );

    cdl_out_latch #(.NUM_COLS(NUM_COLS), .DOT_W(DOT_W)) olat_i (
        .clk(clk), .rst(rst), .stb_i(stb_i), .pol_i(pol_i), .words_i(words),
        .stb_rise_o(stb_rise), .codes_o(codes_o), .half_o(half_o), .valid_o(valid_o)
    );

    AST_PIN_ROLES: assert property (@(posedge clk) disable iff (rst)
        !(sp_l_oe && sp_r_oe) && (sp_l_oe || sp_r_oe)); // R2
endmodule

// File: tb/cdl_loader_tb_top.sv
`timescale 1ns/1ps
module cdl_loader_tb_top;
    localparam int NC = 384;
    localparam int NG = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dir_i = 1'b1, sp_r_in = 1'b0, sp_l_in = 1'b0;
    logic stb_i = 1'b0, pol_i = 1'b0, inv_i = 1'b0;
    logic [35:0] data_i = '0;
    logic sp_r_out, sp_r_oe, sp_l_out, sp_l_oe, valid_o;
    logic [NC*6-1:0] codes_o;
    logic [NC-1:0]   half_o;

    always #2.5 clk = ~clk;

    cdl_loader dut_i (
        .clk(clk), .rst(rst), .dir_i(dir_i),
        .sp_r_in(sp_r_in), .sp_r_out(sp_r_out), .sp_r_oe(sp_r_oe),
        .sp_l_in(sp_l_in), .sp_l_out(sp_l_out), .sp_l_oe(sp_l_oe),
        .stb_i(stb_i), .pol_i(pol_i), .inv_i(inv_i), .data_i(data_i),
        .codes_o(codes_o), .half_o(half_o), .valid_o(valid_o)
    );

    typedef struct {
        logic [NC*6-1:0] codes;
        logic [NC-1:0]   half;
        string           tag;
    } exp_t;

    exp_t       sb_q[$];
    logic [5:0] model [NC];
    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    task automatic check1(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [5:0] dot_val(input int line, input int g, input int k);
        return 6'((line * 37 + g * 7 + k * 11 + 3) & 63);
    endfunction

    task automatic push_expected(input bit pol, input string tag);
        exp_t e;
        for (int c = 0; c < NC; c++) begin
            e.codes[c*6 +: 6] = model[c];
            e.half[c] = ((c % 2) == 0) ? ~pol : pol;
        end
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    // inv_mode: 0 none, 1 all, 2 odd groups only
    task automatic run_line(input int line, input bit dir, input int inv_mode, input bit pol,
                            input int ngroups, input int extra, input string tag);
        @(negedge clk);
        dir_i = dir;
        @(negedge clk);
        check1(dir ? "R2" : "R3", "output pin enable", {62'd0, sp_l_oe, sp_r_oe}, dir ? 64'd2 : 64'd1);
        for (int g = 0; g < ngroups; g++) begin
            logic [35:0] w;
            bit inv;
            if (g > 0) @(negedge clk);
            if (g == NG - 1)
                check1("R4", "start out before clock 64", 64'(dir ? sp_l_out : sp_r_out), 64'd0);
            inv = (inv_mode == 1) || (inv_mode == 2 && (g % 2) == 1);
            for (int k = 0; k < 6; k++) begin
                w[k*6 +: 6] = dot_val(line, g, k);
                model[dir ? (6*g + k) : (NC - 1 - 6*g - k)] = dot_val(line, g, k) ^ (inv ? 6'h3f : 6'h00);
            end
            data_i  = w;
            inv_i   = inv;
            sp_r_in = dir && (g == 0);
            sp_l_in = !dir && (g == 0);
        end
        for (int e = 0; e < extra; e++) begin
            @(negedge clk);
            sp_r_in = 1'b0;
            sp_l_in = 1'b0;
            inv_i   = e[0];
            data_i  = 36'(64'h5a5a_5a5a_5 + 64'(e * 977));
            if (ngroups == NG && e == 0)
                check1("R4", "start out after clock 64", 64'(dir ? sp_l_out : sp_r_out), 64'd1);
            if (ngroups == NG && e == 1)
                check1("R5", "start out one clock", 64'(dir ? sp_l_out : sp_r_out), 64'd0);
        end
        @(negedge clk);
        sp_r_in = 1'b0;
        sp_l_in = 1'b0;
        stb_i = 1'b1;
        pol_i = pol;
        push_expected(pol, tag);
        @(negedge clk);
        check1("R9", "valid cleared at strobe rise", 64'(valid_o), 64'd0);
        stb_i = 1'b0;
        pol_i = ~pol;
        repeat (3) @(negedge clk);
    endtask

    // Monitor: compare each newly valid latch against the scoreboard
    initial begin
        forever begin
            @(posedge valid_o);
            @(negedge clk);
            if (sb_q.size() == 0) begin
                check1("R9", "unexpected valid rise", 64'd1, 64'd0);
            end else begin
                exp_t e;
                int bad;
                e = sb_q.pop_front();
                bad = -1;
                for (int c = 0; c < NC; c++)
                    if (bad < 0 && codes_o[c*6 +: 6] !== e.codes[c*6 +: 6]) bad = c;
                n_checks++;
                if (bad >= 0) begin
                    n_fail++;
                    $display("FAIL %s codes col %0d: actual %0h expected %0h", e.tag, bad,
                             codes_o[bad*6 +: 6], e.codes[bad*6 +: 6]);
                end
                check1("R10", "half select", 64'(half_o[63:0]), 64'(e.half[63:0]));
                check1("R10", "half select top", 64'(half_o[NC-1 -: 64]), 64'(e.half[NC-1 -: 64]));
            end
        end
    end

    initial begin
        for (int c = 0; c < NC; c++) model[c] = 6'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check1("R1", "codes zero after reset", 64'(|codes_o), 64'd0);
        check1("R1", "valid and start outs after reset", {61'd0, valid_o, sp_l_out, sp_r_out}, 64'd0);
        check1("R1", "half after reset", 64'(half_o[63:0]), 64'h5555_5555_5555_5555);
        // ascending fill, no invert, extra clocks past the halt point
        run_line(1, 1'b1, 0, 1'b0, NG, 6, "R2 R6");
        // descending fill, per-clock invert, swapped polarity
        run_line(2, 1'b0, 2, 1'b1, NG, 4, "R3 R7");
        // no token: clocks write nothing, latch shows register unchanged
        run_line(3, 1'b1, 0, 1'b0, 0, 5, "R8 no token");
        // full invert, ascending, strobe in mid-line ends loading
        run_line(4, 1'b1, 1, 1'b1, 10, 0, "R7 R8 partial");
        run_line(5, 1'b1, 0, 1'b0, 0, 8, "R8 after clear");
        repeat (5) @(negedge clk);
        check1("R9", "scoreboard drained", 64'(sb_q.size()), 64'd0);
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule